// File: doc/BRIEF.md
# Sector Buffer Transfer Engine

This block moves data out of a 16 KB sector buffer, one 16-bit word per host read. It keeps a 16-bit data address counter and a 16-bit data byte counter. A trigger command starts a transfer, and a 3-bit destination code chooses its type. For a host read, the host pulls words one at a time. Each word advances the address by two and lowers the byte count by two. For a DMA transfer, the block issues a single request strobe together with the word count for the whole burst. Some other agent moves the data itself.

The block reports its status as an active-low byte. Bit 6 is the pending transfer-end flag, bit 3 is busy and bit 1 is data-available; every other bit always reads 1. It also drives an active-high data-ready flag and an active-high end-of-data flag. The interrupt request is a level. It stays high while the transfer-end flag is pending and the interrupt enable is set. The buffer is a synchronous byte RAM outside the block. The block presents an even byte address and receives the bytes at that address and the next one a cycle later.

Top module: `sbx_xfer_engine`

## Requirements
- R1: After reset `stat_n` is 0xFF, and `irq`, `dma_req`, `data_ready`, `end_of_data` and `host_rvalid` are 0.
- R2: A write with `reg_we`=1 selects a target by `reg_sel`. Code 0 is the control byte (bit 1 output enable, bit 6 interrupt enable). Codes 1 and 2 are the low and high bytes of the byte counter. Codes 3 and 4 are the low and high bytes of the address counter. Code 5 is the trigger and code 6 the acknowledge. The counters read back on `dbc_out` and `dac_out` after the write edge.
- R3: The trigger has no effect while control bit 1 is 0. When it is accepted, busy (`stat_n` bit 3) goes low, bits 15:12 of the byte counter clear, and `data_ready` and `end_of_data` clear.
- R4: On an accepted trigger, `dest_code` 2 or 3 starts a host read. It drives data-available (`stat_n` bit 1) low and sets `data_ready`. Codes 4, 5 and 7 start a DMA transfer. Any other code leaves busy low and starts nothing: no data, no request.
- R5: A host read with data available returns `{byte[a], byte[a+1]}` with a = address & 0x3FFE. The data comes on `host_rdata` with `host_rvalid` high one cycle after `host_rd`. The address then rises by 2 and the byte count falls by 2.
- R6: When the decremented byte count, taken as signed, is at or below zero, the block ends the transfer. The count reloads as 0xF000, busy and data-available go high, the transfer-end flag (`stat_n` bit 6) goes low, `end_of_data` sets and `data_ready` clears. A count that stays positive keeps the transfer running.
- R7: A host read while data-available is high returns 0xFFFF and changes neither counter nor any flag.
- R8: A DMA transfer raises `dma_req` for exactly one cycle, the cycle after the trigger, with `dma_words` = (count+1)/2. On that edge the address advances by twice the word count and the R6 end sequence runs.
- R9: `irq` is high exactly when control bit 6 is set and the transfer-end flag is pending. An acknowledge returns the flag high and clears bits 15:12 of the byte counter.
- R10: A control write with bit 1 clear aborts a transfer: busy and data-available go high, and later host reads return 0xFFFF.
- R11: The buffer address wraps: an address counter of 0x4000 reads buffer bytes 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Write target code |
| reg_wdata | input | 8 | Write data byte |
| dest_code | input | 3 | Transfer destination code, sampled at trigger |
| host_rd | input | 1 | Host word read request |
| host_rdata | output | 16 | Returned host word |
| host_rvalid | output | 1 | Host word valid, one cycle after request |
| buf_rd_en | output | 1 | Buffer read enable |
| buf_addr | output | 14 | Even buffer byte address |
| buf_byte_hi | input | 8 | Buffer byte at `buf_addr`, one cycle later |
| buf_byte_lo | input | 8 | Buffer byte at `buf_addr`+1, one cycle later |
| stat_n | output | 8 | Active-low status byte |
| data_ready | output | 1 | Host data ready flag |
| end_of_data | output | 1 | Transfer completed flag |
| irq | output | 1 | Transfer-end interrupt request level |
| dma_req | output | 1 | One-cycle DMA request strobe |
| dma_words | output | 16 | Word count for the DMA burst |
| dac_out | output | 16 | Address counter |
| dbc_out | output | 16 | Byte counter |

## Verification
Both counters appear on ports after every edge, so a wrong step, mask or reload shows on the next sample, one cycle after the command that caused it. A wrong address or byte order shows one cycle later in the word returned by the following host read. A wrong flag update shows at once on `stat_n`, `irq` or `dma_req`. A missed or extra end of transfer also shows later: a read that should return buffer data returns 0xFFFF, or the reverse.

// File: rtl/sbx_pkg.sv
package sbx_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;

    // write target codes on reg_sel
    typedef enum logic [2:0] {
        SEL_CTRL   = 3'd0,
        SEL_CNT_LO = 3'd1,
        SEL_CNT_HI = 3'd2,
        SEL_ADR_LO = 3'd3,
        SEL_ADR_HI = 3'd4,
        SEL_TRIG   = 3'd5,
        SEL_ACK    = 3'd6,
        SEL_NONE   = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        XF_IDLE,
        XF_HOST,
        XF_DMA
    } xfer_state_e;

    typedef enum logic [1:0] {
        DST_NONE,
        DST_HOST,
        DST_DMA
    } dest_kind_e;

    localparam int CTRL_OUTEN_BIT = 1;
    localparam int CTRL_IRQEN_BIT = 6;

    localparam int ST_END_BIT   = 6;
    localparam int ST_BUSY_BIT  = 3;
    localparam int ST_AVAIL_BIT = 1;

    typedef struct packed {
        logic end_n;
        logic busy_n;
        logic avail_n;
        logic ready;
        logic eod;
    } flags_t;

    typedef struct packed {
        logic dbc_wr_lo;
        logic dbc_wr_hi;
        logic dac_wr_lo;
        logic dac_wr_hi;
        logic mask_top;
        logic step;
        logic dma_adv;
        logic reload;
    } cnt_cmd_t;

    function automatic dest_kind_e classify_dest(input logic [2:0] code);
        dest_kind_e k;
        case (code)
            3'd2, 3'd3:       k = DST_HOST;
            3'd4, 3'd5, 3'd7: k = DST_DMA;
            default:          k = DST_NONE;
        endcase
        return k;
    endfunction

    function automatic logic [BYTE_W-1:0] pack_status(input flags_t f);
        logic [BYTE_W-1:0] s;
        s = '1;
        s[ST_END_BIT]   = f.end_n;
        s[ST_BUSY_BIT]  = f.busy_n;
        s[ST_AVAIL_BIT] = f.avail_n;
        return s;
    endfunction

endpackage

// File: rtl/sbx_counters.sv
module sbx_counters
    import sbx_pkg::*;
#(
    parameter int TOP_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  cnt_cmd_t          cmd,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  dac,
    output logic [CNT_W-1:0]  dbc,
    output logic              step_ends,
    output logic [CNT_W-1:0]  dma_words
);
    localparam int LOW_W = CNT_W - TOP_W;
    localparam logic [CNT_W-1:0] RELOAD = {{TOP_W{1'b1}}, {LOW_W{1'b0}}};
    localparam logic [CNT_W-1:0] STEP   = CNT_W'(2);

    logic [CNT_W-1:0] dbc_dec;
    logic [CNT_W:0]   dbc_plus;
    logic [CNT_W-1:0] dma_bytes;

    assign dbc_dec   = dbc - STEP;
    // signed result at or below zero: sign bit set or all zero
    assign step_ends = dbc_dec[CNT_W-1] || (dbc_dec == '0);
    assign dbc_plus  = {1'b0, dbc} + {{CNT_W{1'b0}}, 1'b1};
    assign dma_words = dbc_plus[CNT_W:1];
    assign dma_bytes = {dma_words[CNT_W-2:0], 1'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            dac <= '0;
            dbc <= '0;
        end else begin
            if (cmd.dac_wr_lo)
                dac[BYTE_W-1:0] <= wdata;
            else if (cmd.dac_wr_hi)
                dac[CNT_W-1:BYTE_W] <= wdata;
            else if (cmd.step)
                dac <= dac + STEP;
            else if (cmd.dma_adv)
                dac <= dac + dma_bytes;

            if (cmd.dbc_wr_lo)
                dbc[BYTE_W-1:0] <= wdata;
            else if (cmd.dbc_wr_hi)
                dbc[CNT_W-1:BYTE_W] <= wdata;
            else if (cmd.reload)
                dbc <= RELOAD;
            else if (cmd.step)
                dbc <= dbc_dec;
            else if (cmd.mask_top)
                dbc[CNT_W-1 -: TOP_W] <= '0;
        end
    end

endmodule

// File: rtl/sbx_sequencer.sv
module sbx_sequencer
    import sbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  logic [2:0]        dest_code,
    input  logic              host_rd,
    input  logic              step_ends,
    output cnt_cmd_t          cmd,
    output flags_t            flags,
    output logic [BYTE_W-1:0] ctrl_q,
    output logic              host_take,
    output logic              dma_req,
    output logic              irq
);
    xfer_state_e state;
    reg_sel_e    wr;
    dest_kind_e  kind;
    logic        out_en;
    logic        irq_en;
    logic        trig_fire;
    logic        abort;
    logic        dma_fire;
    logic        finish;

    always_comb begin
        wr = reg_we ? reg_sel_e'(reg_sel) : SEL_NONE;
    end

    assign kind      = classify_dest(dest_code);
    assign out_en    = ctrl_q[CTRL_OUTEN_BIT];
    assign irq_en    = ctrl_q[CTRL_IRQEN_BIT];
    assign trig_fire = (wr == SEL_TRIG) && out_en;
    assign abort     = (wr == SEL_CTRL) && !reg_wdata[CTRL_OUTEN_BIT];
    assign host_take = host_rd && !flags.avail_n && !trig_fire && !abort;
    assign dma_fire  = (state == XF_DMA) && !trig_fire && !abort;
    assign finish    = (host_take && step_ends) || dma_fire;
    assign dma_req   = (state == XF_DMA);
    assign irq       = irq_en && !flags.end_n;

    always_comb begin
        cmd           = '0;
        cmd.dbc_wr_lo = (wr == SEL_CNT_LO);
        cmd.dbc_wr_hi = (wr == SEL_CNT_HI);
        cmd.dac_wr_lo = (wr == SEL_ADR_LO);
        cmd.dac_wr_hi = (wr == SEL_ADR_HI);
        cmd.mask_top  = trig_fire || (wr == SEL_ACK);
        cmd.step      = host_take;
        cmd.dma_adv   = dma_fire;
        cmd.reload    = finish;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags  <= '{end_n: 1'b1, busy_n: 1'b1, avail_n: 1'b1, ready: 1'b0, eod: 1'b0};
            ctrl_q <= '0;
            state  <= XF_IDLE;
        end else begin
            if (wr == SEL_CTRL)
                ctrl_q <= reg_wdata;
            if (wr == SEL_ACK)
                flags.end_n <= 1'b1;

            if (abort) begin
                flags.busy_n  <= 1'b1;
                flags.avail_n <= 1'b1;
                state         <= XF_IDLE;
            end else if (trig_fire) begin
                flags.busy_n <= 1'b0;
                flags.eod    <= 1'b0;
                flags.ready  <= 1'b0;
                case (kind)
                    DST_HOST: begin
                        flags.avail_n <= 1'b0;
                        flags.ready   <= 1'b1;
                        state         <= XF_HOST;
                    end
                    DST_DMA: begin
                        flags.avail_n <= 1'b1;
                        state         <= XF_DMA;
                    end
                    default: begin
                        flags.avail_n <= 1'b1;
                        state         <= XF_IDLE;
                    end
                endcase
            end else if (finish) begin
                flags.end_n   <= 1'b0;
                flags.busy_n  <= 1'b1;
                flags.avail_n <= 1'b1;
                flags.eod     <= 1'b1;
                flags.ready   <= 1'b0;
                state         <= XF_IDLE;
            end
        end
    end

endmodule

// File: rtl/sbx_xfer_engine.sv
module sbx_xfer_engine
    import sbx_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int TOP_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    input  logic [2:0]        dest_code,
    input  logic              host_rd,
    output logic [15:0]       host_rdata,
    output logic              host_rvalid,
    output logic              buf_rd_en,
    output logic [ADDR_W-1:0] buf_addr,
    input  logic [7:0]        buf_byte_hi,
    input  logic [7:0]        buf_byte_lo,
    output logic [7:0]        stat_n,
    output logic              data_ready,
    output logic              end_of_data,
    output logic              irq,
    output logic              dma_req,
    output logic [15:0]       dma_words,
    output logic [15:0]       dac_out,
    output logic [15:0]       dbc_out
);
    localparam logic [CNT_W-1:0] NO_DATA = '1;

    cnt_cmd_t          cmd;
    flags_t            flags;
    logic [BYTE_W-1:0] ctrl_q;
    logic              host_take;
    logic              step_ends;
    logic              served_q;
    logic              rvalid_q;

    sbx_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .dest_code (dest_code),
        .host_rd   (host_rd),
        .step_ends (step_ends),
        .cmd       (cmd),
        .flags     (flags),
        .ctrl_q    (ctrl_q),
        .host_take (host_take),
        .dma_req   (dma_req),
        .irq       (irq)
    );

    sbx_counters #(.TOP_W(TOP_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .wdata     (reg_wdata),
        .dac       (dac_out),
        .dbc       (dbc_out),
        .step_ends (step_ends),
        .dma_words (dma_words)
    );

    // word-aligned buffer address, upper counter bits drop out (wrap)
    assign buf_addr  = {dac_out[ADDR_W-1:1], 1'b0};
    assign buf_rd_en = host_take;

    always_ff @(posedge clk) begin
        if (rst) begin
            served_q <= 1'b0;
            rvalid_q <= 1'b0;
        end else begin
            served_q <= host_take;
            rvalid_q <= host_rd;
        end
    end

    assign host_rvalid = rvalid_q;
    assign host_rdata  = served_q ? {buf_byte_hi, buf_byte_lo} : NO_DATA;
    assign stat_n      = pack_status(flags);
    assign data_ready  = flags.ready;
    assign end_of_data = flags.eod;

endmodule

// File: rtl/sbx_xfer_engine_checker.sv
module sbx_xfer_engine_checker (
    input logic        clk,
    input logic        rst,
    input logic        reg_we,
    input logic        host_rd,
    input logic        host_rvalid,
    input logic [7:0]  stat_n,
    input logic        irq,
    input logic        irq_en,
    input logic        dma_req,
    input logic [15:0] dac,
    input logic [15:0] dbc
);
    a_r7_idle_read_holds: assert property (@(posedge clk) disable iff (rst)
        (host_rd && stat_n[1] && !reg_we) |=> ($stable(dac) && $stable(dbc)));

    a_r5_step_advances: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !stat_n[1] && !reg_we) |=> (dac == $past(dac) + 16'd2));

    a_r5_response_next: assert property (@(posedge clk) disable iff (rst)
        host_rd |=> host_rvalid);

    a_r6_end_reload: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !stat_n[1] && !reg_we && ($signed(dbc) <= 16'sd2))
        |=> (dbc == 16'hF000 && stat_n[3] && stat_n[1] && !stat_n[6]));

    a_r8_dma_single: assert property (@(posedge clk) disable iff (rst)
        dma_req |=> !dma_req);

    a_r9_irq_level: assert property (@(posedge clk) disable iff (rst)
        irq |-> (!stat_n[6] && irq_en));

    a_r4_avail_implies_busy: assert property (@(posedge clk) disable iff (rst)
        !stat_n[1] |-> !stat_n[3]);

endmodule

bind sbx_xfer_engine sbx_xfer_engine_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_we      (reg_we),
    .host_rd     (host_rd),
    .host_rvalid (host_rvalid),
    .stat_n      (stat_n),
    .irq         (irq),
    .irq_en      (ctrl_q[6]),
    .dma_req     (dma_req),
    .dac         (dac_out),
    .dbc         (dbc_out)
);

// File: tb/sbx_xfer_engine_test.sv
module sbx_xfer_engine_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [2:0]  dest_code = 3'd0;
    logic        host_rd = 1'b0;
    logic [15:0] host_rdata;
    logic        host_rvalid;
    logic        buf_rd_en;
    logic [13:0] buf_addr;
    logic [7:0]  buf_byte_hi;
    logic [7:0]  buf_byte_lo;
    logic [7:0]  stat_n;
    logic        data_ready;
    logic        end_of_data;
    logic        irq;
    logic        dma_req;
    logic [15:0] dma_words;
    logic [15:0] dac_out;
    logic [15:0] dbc_out;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    logic [7:0]  mem [0:16383];
    logic [15:0] exp_q [$];
    string       tag_q [$];
    logic [15:0] m_dac;
    logic [15:0] m_dbc;
    bit          m_live;

    always #5 clk = ~clk;

    sbx_xfer_engine uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .dest_code(dest_code), .host_rd(host_rd),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .buf_rd_en(buf_rd_en), .buf_addr(buf_addr),
        .buf_byte_hi(buf_byte_hi), .buf_byte_lo(buf_byte_lo),
        .stat_n(stat_n), .data_ready(data_ready), .end_of_data(end_of_data),
        .irq(irq), .dma_req(dma_req), .dma_words(dma_words),
        .dac_out(dac_out), .dbc_out(dbc_out)
    );

    // synchronous byte buffer
    always @(posedge clk) begin
        if (buf_rd_en) begin
            buf_byte_hi <= mem[buf_addr];
            buf_byte_lo <= mem[buf_addr | 14'd1];
        end
    end

    function automatic void chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endfunction

    // monitor: pop expected host words as responses appear
    always @(negedge clk) begin
        if (!rst && host_rvalid) begin
            if (exp_q.size() == 0) begin
                chk("R5 unexpected response", 32'd1, 32'd0);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, {16'd0, host_rdata}, {16'd0, e});
            end
        end
    end

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // driver: compute expected word from the model, push, issue read
    task automatic host_word(input string tag);
        logic [15:0] e;
        int a;
        if (m_live) begin
            a = int'(m_dac & 16'h3FFE);
            e = {mem[a], mem[a + 1]};
            m_dac = m_dac + 16'd2;
            m_dbc = m_dbc - 16'd2;
            if ($signed(m_dbc) <= 0) begin
                m_dbc = 16'hF000;
                m_live = 1'b0;
            end
        end else begin
            e = 16'hFFFF;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic load_counters(input logic [15:0] cnt, input logic [15:0] adr);
        wr(3'd1, cnt[7:0]);
        wr(3'd2, cnt[15:8]);
        wr(3'd3, adr[7:0]);
        wr(3'd4, adr[15:8]);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired, R1 to R11 incomplete");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16384; i++) mem[i] = 8'((i * 13) + (i >> 7));
        m_dac = 16'd0; m_dbc = 16'd0; m_live = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 stat_n", {24'd0, stat_n}, 32'hFF);
        chk("R1 irq/dma/ready/eod/rvalid",
            {27'd0, irq, dma_req, data_ready, end_of_data, host_rvalid}, 32'd0);

        // R7 read with no transfer
        host_word("R7 empty read word");
        chk("R7 dac unchanged", {16'd0, dac_out}, 32'd0);
        chk("R7 dbc unchanged", {16'd0, dbc_out}, 32'd0);

        // R2 register writes, R3 trigger gated by output enable
        load_counters(16'hF005, 16'h3FFA);
        chk("R2 dbc readback", {16'd0, dbc_out}, 32'hF005);
        chk("R2 dac readback", {16'd0, dac_out}, 32'h3FFA);
        wr(3'd0, 8'h40);
        dest_code = 3'd2;
        wr(3'd5, 8'h00);
        chk("R3 gated trigger stat", {24'd0, stat_n}, 32'hFF);
        chk("R3 gated trigger dbc", {16'd0, dbc_out}, 32'hF005);

        // R3/R4 accepted host trigger
        wr(3'd0, 8'h42);
        wr(3'd5, 8'h00);
        chk("R4 host stat", {24'd0, stat_n}, 32'hF5);
        chk("R3 top nibble cleared", {16'd0, dbc_out}, 32'h0005);
        chk("R4 data_ready", {31'd0, data_ready}, 32'd1);
        m_dac = 16'h3FFA; m_dbc = 16'h0005; m_live = 1'b1;

        // R5 three words, last ends on a negative count (R6)
        host_word("R5 word 0");
        chk("R5 dac step", {16'd0, dac_out}, {16'd0, m_dac});
        chk("R5 dbc step", {16'd0, dbc_out}, {16'd0, m_dbc});
        chk("R6 still running", {24'd0, stat_n}, 32'hF5);
        host_word("R5 word 1");
        host_word("R5 word 2 at top of buffer");
        chk("R6 reload", {16'd0, dbc_out}, 32'hF000);
        chk("R6 end stat", {24'd0, stat_n}, 32'hBF);
        chk("R6 eod/ready", {30'd0, end_of_data, data_ready}, 32'b10);
        chk("R9 irq at end", {31'd0, irq}, 32'd1);
        chk("R11 dac past buffer", {16'd0, dac_out}, 32'h4000);
        host_word("R7 read after end");
        chk("R7 dac unchanged after end", {16'd0, dac_out}, 32'h4000);

        // R9 acknowledge
        wr(3'd6, 8'h00);
        chk("R9 ack stat", {24'd0, stat_n}, 32'hFF);
        chk("R9 ack irq", {31'd0, irq}, 32'd0);
        chk("R9 ack masks dbc", {16'd0, dbc_out}, 32'h0000);

        // R11 wrap, R6 exact zero ends after one non-ending step
        wr(3'd1, 8'h04);
        dest_code = 3'd3;
        wr(3'd5, 8'h00);
        m_dac = 16'h4000; m_dbc = 16'h0004; m_live = 1'b1;
        host_word("R11 wrapped word at byte 0");
        chk("R6 positive count keeps running", {24'd0, stat_n}, 32'hF5);
        host_word("R6 zero count word");
        chk("R6 zero ends", {24'd0, stat_n}, 32'hBF);
        chk("R6 zero reload", {16'd0, dbc_out}, 32'hF000);

        // R9 interrupt disabled, then enabled while pending
        wr(3'd6, 8'h00);
        wr(3'd0, 8'h02);
        load_counters(16'h0002, 16'h0123);
        dest_code = 3'd2;
        wr(3'd5, 8'h00);
        m_dac = 16'h0123; m_dbc = 16'h0002; m_live = 1'b1;
        host_word("R5 odd address word");
        chk("R9 pending without enable stat", {24'd0, stat_n}, 32'hBF);
        chk("R9 no irq without enable", {31'd0, irq}, 32'd0);
        wr(3'd0, 8'h42);
        chk("R9 irq when enabled later", {31'd0, irq}, 32'd1);
        wr(3'd6, 8'h00);
        chk("R9 irq drops on ack", {31'd0, irq}, 32'd0);

        // R8 DMA with odd count and masked top nibble
        load_counters(16'hA007, 16'h0100);
        dest_code = 3'd5;
        wr(3'd5, 8'h00);
        chk("R8 dma_req pulse", {31'd0, dma_req}, 32'd1);
        chk("R8 dma_words odd", {16'd0, dma_words}, 32'd4);
        chk("R8 busy during dma", {24'd0, stat_n}, 32'hF7);
        @(negedge clk);
        chk("R8 dma_req single", {31'd0, dma_req}, 32'd0);
        chk("R8 dac advance", {16'd0, dac_out}, 32'h0108);
        chk("R8 dbc reload", {16'd0, dbc_out}, 32'hF000);
        chk("R8 end stat", {24'd0, stat_n}, 32'hBF);
        chk("R8 eod and irq", {30'd0, end_of_data, irq}, 32'b11);

        // R8 DMA even count, code 7
        wr(3'd6, 8'h00);
        load_counters(16'h0008, 16'h2000);
        dest_code = 3'd7;
        wr(3'd5, 8'h00);
        chk("R8 dma_words even", {16'd0, dma_words}, 32'd4);
        @(negedge clk);
        chk("R8 dac advance even", {16'd0, dac_out}, 32'h2008);

        // R4 DMA code 4
        wr(3'd6, 8'h00);
        load_counters(16'h0001, 16'h0000);
        dest_code = 3'd4;
        wr(3'd5, 8'h00);
        chk("R4 code 4 dma", {15'd0, dma_req, dma_words}, 32'h10001);

        // R4 invalid code starts nothing
        @(negedge clk);
        wr(3'd6, 8'h00);
        dest_code = 3'd6;
        wr(3'd5, 8'h00);
        chk("R4 invalid stat", {24'd0, stat_n}, 32'hF7);
        chk("R4 invalid no dma", {31'd0, dma_req}, 32'd0);
        @(negedge clk);
        chk("R4 invalid still no dma", {31'd0, dma_req}, 32'd0);
        chk("R4 invalid no ready", {31'd0, data_ready}, 32'd0);
        host_word("R4 invalid gives no data");

        // R10 abort
        wr(3'd0, 8'h40);
        chk("R10 abort idle stat", {24'd0, stat_n}, 32'hFF);
        wr(3'd0, 8'h42);
        load_counters(16'h0010, 16'h0040);
        dest_code = 3'd2;
        wr(3'd5, 8'h00);
        m_dac = 16'h0040; m_dbc = 16'h0010; m_live = 1'b1;
        host_word("R5 word before abort");
        wr(3'd0, 8'h40);
        m_live = 1'b0;
        chk("R10 abort stat", {24'd0, stat_n}, 32'hFF);
        host_word("R10 read after abort");
        chk("R10 dac held", {16'd0, dac_out}, 32'h0042);

        repeat (3) @(negedge clk);
        chk("R5 all responses seen", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule